// File: doc/BRIEF.md
# Quiz Buzzer First-Press Lockout

This block decides which of four contestant buttons went down first. It holds that contestant's number and shows it on a common-anode seven-segment digit. An alarm enable and a square-wave tone run while an entry is held. Once one entry is held, presses from every other contestant are ignored. An organiser pushbutton then clears the held entry, silences the tone and brings the digit back to 0.

Each raw button line, and the organiser clear line, passes through a two-flop synchroniser and then a debounce filter. A line must hold its new level for `DEB_CYCLES` consecutive clocks before the filter accepts it. The held entry is kept internally as one active-low flag per contestant. A priority encoder turns these flags into a BCD number from 0 to 4. The segment pattern and the alarm enable are both derived from that number and are registered. The tone divider toggles its output every `TONE_DIV` clocks while the alarm enable is high.

Top module: `quiz_lockout`

## Requirements
- R1: A debounced press by contestant k (k = 1..4, on `btn_i[k-1]`) while nothing is held is captured, and the digit then shows k.
- R2: While an entry is held, presses by any contestant leave the displayed digit unchanged.
- R3: If several armed contestants are first accepted on the same clock edge, only the lowest-numbered one is captured.
- R4: Each input line passes through 2 synchroniser flops and a filter that accepts a level only after `DEB_CYCLES` consecutive clocks. A press shorter than that is never captured.
- R5: `seg_n_o` is active-low with segment a at bit 0 through g at bit 6. The patterns are 7'h40 for 0, 7'h79 for 1, 7'h24 for 2, 7'h30 for 3 and 7'h19 for 4.
- R6: `alarm_o` is 1 exactly when an entry is held, one clock after the capture edge, and is 0 otherwise.
- R7: A debounced high level on `clear_i` releases the held entry, so the digit shows 0 and `alarm_o` falls. A clear pulse shorter than `DEB_CYCLES` has no effect.
- R8: A synchronous high `rst` puts the outputs at digit 0 (7'h40), `alarm_o` 0 and `tone_o` 0.
- R9: `tone_o` is held at 0 while `alarm_o` is 0. While `alarm_o` is 1, it toggles once every `TONE_DIV` clocks.
- R10: A button still held down when the clear is accepted cannot win until it has been seen released and then pressed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| btn_i | input | 4 | Raw contestant buttons, 1 = pressed |
| clear_i | input | 1 | Raw organiser clear pushbutton, 1 = pressed |
| seg_n_o | output | 7 | Active-low segments, bit 0 = a to bit 6 = g |
| alarm_o | output | 1 | Alarm enable, 1 while an entry is held |
| tone_o | output | 1 | Square-wave tone |

## Verification
The hardest case to reach is a button that is still down when the organiser's clear is accepted. It must stay locked out after the clear is let go. To reach it, the bench has contestant 4 win and keep the button held while the clear goes through its full debounce and is released. The bench then waits and checks that the digit stays at 0. Only after a real release and a second press does the bench expect 4 to appear. A same-edge press by two contestants and presses shorter than the filter length cover the other corners. A behavioural model of the whole pipeline is compared against every output on every clock.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // active-low pattern, bit 0 = a ... bit 6 = g
  function automatic seg_t seg_pattern_n(input logic [BCD_W-1:0] d);
    seg_t on;
    case (d)
      4'd0: on = 7'h3F;
      4'd1: on = 7'h06;
      4'd2: on = 7'h5B;
      4'd3: on = 7'h4F;
      4'd4: on = 7'h66;
      4'd5: on = 7'h6D;
      4'd6: on = 7'h7D;
      4'd7: on = 7'h07;
      4'd8: on = 7'h7F;
      4'd9: on = 7'h6F;
      default: on = 7'h40;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/quiz_btn_cond.sv
module quiz_btn_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_o <= 1'b0;
    end else if (synced != level_o) begin
      if (run_q == CNT_W'(DEB_CYCLES - 1)) begin
        level_o <= synced;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/quiz_capture.sv
module quiz_capture #(
  parameter int N_PLAYERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] press_i,
  input  logic                 clear_i,
  output logic [N_PLAYERS-1:0] flag_n_o
);
  logic [N_PLAYERS-1:0] armed_q;
  logic [N_PLAYERS-1:0] req;
  logic [N_PLAYERS-1:0] pick;
  logic                 idle;

  assign req  = press_i & armed_q;
  assign idle = &flag_n_o;

  always_comb begin
    pick = '0;
    for (int i = N_PLAYERS - 1; i >= 0; i--) begin
      if (req[i]) pick = N_PLAYERS'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n_o <= '1;
      armed_q  <= '0;
    end else if (clear_i) begin
      flag_n_o <= '1;
      armed_q  <= ~press_i;
    end else begin
      armed_q <= armed_q | ~press_i;
      if (idle) flag_n_o <= ~pick;
    end
  end
endmodule

// File: rtl/quiz_display.sv
module quiz_display
  import quiz_pkg::*;
#(
  parameter int N_PLAYERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] flag_n_i,
  output seg_t                 seg_n_o,
  output logic                 alarm_o
);
  logic [BCD_W-1:0] digit;

  always_comb begin
    digit = '0;
    for (int i = N_PLAYERS - 1; i >= 0; i--) begin
      if (!flag_n_i[i]) digit = BCD_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_o <= seg_pattern_n('0);
      alarm_o <= 1'b0;
    end else begin
      seg_n_o <= seg_pattern_n(digit);
      alarm_o <= ~&flag_n_i;
    end
  end
endmodule

// File: rtl/quiz_tone.sv
module quiz_tone #(
  parameter int TONE_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tone_o
);
  localparam int DIV_W = $clog2(TONE_DIV);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      div_q  <= '0;
      tone_o <= 1'b0;
    end else if (div_q == DIV_W'(TONE_DIV - 1)) begin
      div_q  <= '0;
      tone_o <= ~tone_o;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/quiz_lockout.sv
module quiz_lockout
  import quiz_pkg::*;
#(
  parameter int N_PLAYERS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4,
  parameter int TONE_DIV    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_PLAYERS-1:0] btn_i,
  input  logic                 clear_i,
  output logic [SEG_W-1:0]     seg_n_o,
  output logic                 alarm_o,
  output logic                 tone_o
);
  localparam int LINES = N_PLAYERS + 1;

  logic [LINES-1:0]     raw_lines;
  logic [LINES-1:0]     clean_lines;
  logic [N_PLAYERS-1:0] press;
  logic                 clr_db;
  logic [N_PLAYERS-1:0] flag_n;

  assign raw_lines = {clear_i, btn_i};
  assign press     = clean_lines[N_PLAYERS-1:0];
  assign clr_db    = clean_lines[LINES-1];

  for (genvar g = 0; g < LINES; g++) begin : g_cond
    quiz_btn_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) u_cond (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_lines[g]),
      .level_o(clean_lines[g])
    );
  end

  quiz_capture #(.N_PLAYERS(N_PLAYERS)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .press_i (press),
    .clear_i (clr_db),
    .flag_n_o(flag_n)
  );

  quiz_display #(.N_PLAYERS(N_PLAYERS)) u_display (
    .clk     (clk),
    .rst     (rst),
    .flag_n_i(flag_n),
    .seg_n_o (seg_n_o),
    .alarm_o (alarm_o)
  );

  quiz_tone #(.TONE_DIV(TONE_DIV)) u_tone (
    .clk   (clk),
    .rst   (rst),
    .run_i (alarm_o),
    .tone_o(tone_o)
  );
endmodule

// File: rtl/quiz_lockout_chk.sv
module quiz_lockout_chk #(
  parameter int N_PLAYERS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr_db,
  input logic [N_PLAYERS-1:0] flag_n,
  input logic [6:0]           seg_n_o,
  input logic                 alarm_o,
  input logic                 tone_o
);
  // R3: never more than one held flag
  assert_single_winner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~flag_n));

  // R2: a held entry does not move until a clear
  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!(&flag_n) && !clr_db) |=> (flag_n == $past(flag_n)));

  // R7: accepted clear releases the entry
  assert_clear_releases_R7: assert property (@(posedge clk) disable iff (rst)
    clr_db |=> (&flag_n));

  // R6: alarm follows whether the digit is non-zero
  assert_alarm_vs_digit_R6: assert property (@(posedge clk) disable iff (rst)
    alarm_o == (seg_n_o != 7'h40));

  // R9: tone silent without alarm
  assert_tone_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !alarm_o |=> !tone_o);

  // R8: reset leaves outputs quiet
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!alarm_o && !tone_o && seg_n_o == 7'h40));
endmodule

bind quiz_lockout quiz_lockout_chk #(.N_PLAYERS(N_PLAYERS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr_db (clr_db),
  .flag_n (flag_n),
  .seg_n_o(seg_n_o),
  .alarm_o(alarm_o),
  .tone_o (tone_o)
);

// File: tb/sim_quiz_lockout.sv
module sim_quiz_lockout;
  localparam int N   = 4;
  localparam int DEB = 4;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] btn = '0;
  logic       clr = 1'b0;
  logic [6:0] seg_n;
  logic       alarm;
  logic       tone;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  quiz_lockout #(.N_PLAYERS(N), .SYNC_STAGES(2), .DEB_CYCLES(DEB), .TONE_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .btn_i(btn), .clear_i(clr),
    .seg_n_o(seg_n), .alarm_o(alarm), .tone_o(tone)
  );

  // ---------- behavioural reference model ----------
  int m_s1 [5];
  int m_s2 [5];
  int m_db [5];
  int m_cnt[5];
  int m_flag;    // 0 = none, else contestant number
  int m_armed[4];
  int m_digit;
  int m_alarm;
  int m_tone;
  int m_div;

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h40;
      1: return 7'h79;
      2: return 7'h24;
      3: return 7'h30;
      4: return 7'h19;
      default: return 7'h7F;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_tone = 0; m_div = 0; m_digit = 0; m_alarm = 0; m_flag = 0;
      for (int i = 0; i < 5; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_db[i] = 0; m_cnt[i] = 0;
      end
      for (int i = 0; i < 4; i++) m_armed[i] = 0;
    end else begin
      // tone from old alarm
      if (m_alarm == 0) begin
        m_div = 0; m_tone = 0;
      end else if (m_div == DIV - 1) begin
        m_div = 0; m_tone = 1 - m_tone;
      end else m_div++;
      // display from old flag
      m_digit = m_flag;
      m_alarm = (m_flag != 0) ? 1 : 0;
      // capture from old debounced levels
      if (m_db[4] == 1) begin
        m_flag = 0;
        for (int i = 0; i < 4; i++) m_armed[i] = 1 - m_db[i];
      end else begin
        int win;
        win = 0;
        for (int i = 3; i >= 0; i--)
          if (m_db[i] == 1 && m_armed[i] == 1) win = i + 1;
        if (m_flag == 0) m_flag = win;
        for (int i = 0; i < 4; i++) if (m_db[i] == 0) m_armed[i] = 1;
      end
      // debounce from old synchroniser output
      for (int i = 0; i < 5; i++) begin
        if (m_s2[i] != m_db[i]) begin
          if (m_cnt[i] == DEB - 1) begin
            m_db[i] = m_s2[i]; m_cnt[i] = 0;
          end else m_cnt[i]++;
        end else m_cnt[i] = 0;
      end
      for (int i = 0; i < 5; i++) begin
        m_s2[i] = m_s1[i];
        m_s1[i] = (i == 4) ? int'(clr) : int'(btn[i]);
      end
    end
  end

  // ---------- per-clock comparison ----------
  always @(negedge clk) begin
    if (!rst && cyc > 1) begin
      n_checks++;
      if (seg_n !== pat(m_digit)) begin
        n_fail++;
        $display("FAIL R5 cycle %0d seg_n actual %h expected %h", cyc, seg_n, pat(m_digit));
      end
      n_checks++;
      if (alarm !== m_alarm[0]) begin
        n_fail++;
        $display("FAIL R6 cycle %0d alarm actual %b expected %0d", cyc, alarm, m_alarm);
      end
      n_checks++;
      if (tone !== m_tone[0]) begin
        n_fail++;
        $display("FAIL R9 cycle %0d tone actual %b expected %0d", cyc, tone, m_tone);
      end
    end
  end

  // ---------- named scenario checks ----------
  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear;
    clr = 1'b1; wait_n(10); clr = 1'b0; wait_n(12);
  endtask

  initial begin
    wait_n(100000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int toggles;
    logic prev;
    wait_n(8);
    rst = 1'b0;
    wait_n(2);
    chk("R8 reset digit", seg_n, 7'h40);
    chk("R8 reset alarm/tone", {5'd0, alarm, tone}, 7'h00);

    // R4: glitch shorter than filter is ignored
    btn[0] = 1'b1; wait_n(DEB - 1); btn[0] = 1'b0; wait_n(20);
    chk("R4 short press ignored", seg_n, 7'h40);

    // R1 + R6: contestant 2 wins
    btn[1] = 1'b1; wait_n(15);
    chk("R1 digit 2 shown", seg_n, 7'h24);
    chk("R6 alarm on", {6'd0, alarm}, 7'h01);

    // R9: exactly 4 tone toggles over 32 clocks
    toggles = 0; prev = tone;
    for (int k = 0; k < 32; k++) begin
      wait_n(1);
      if (tone != prev) toggles++;
      prev = tone;
    end
    chk("R9 tone toggle count", 7'(toggles), 7'd4);

    // R2: later presses locked out
    btn[0] = 1'b1; btn[3] = 1'b1; wait_n(15);
    chk("R2 lockout keeps digit 2", seg_n, 7'h24);
    btn = '0; wait_n(12);

    // R7: short clear ignored, long clear accepted
    clr = 1'b1; wait_n(2); clr = 1'b0; wait_n(15);
    chk("R7 short clear ignored", seg_n, 7'h24);
    do_clear();
    chk("R7 clear shows 0", seg_n, 7'h40);
    chk("R7 clear alarm off", {6'd0, alarm}, 7'h00);

    // R3: same-edge presses, lower number wins
    btn[2] = 1'b1; btn[3] = 1'b1; wait_n(15);
    chk("R3 tie gives 3", seg_n, 7'h30);
    btn = '0; wait_n(10);
    do_clear();

    // R10: button held through clear stays locked out
    btn[3] = 1'b1; wait_n(15);
    chk("R1 digit 4 shown", seg_n, 7'h19);
    do_clear();
    wait_n(20);
    chk("R10 held button ignored after clear", seg_n, 7'h40);
    btn[3] = 1'b0; wait_n(12);
    btn[3] = 1'b1; wait_n(15);
    chk("R10 re-press wins", seg_n, 7'h19);
    btn = '0; wait_n(10);
    do_clear();

    // R1: contestant 1
    btn[0] = 1'b1; wait_n(15);
    chk("R1 digit 1 shown", seg_n, 7'h79);
    btn = '0; wait_n(10);

    // R8: reset mid-alarm
    rst = 1'b1; wait_n(2);
    chk("R8 reset clears digit", seg_n, 7'h40);
    chk("R8 reset clears alarm/tone", {5'd0, alarm, tone}, 7'h00);
    rst = 1'b0; wait_n(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule